// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Stage

This block is the write side of a narrow fall-through FIFO slice. A word reaches it in one of two ways. It can be captured whole from a parallel bus while a load strobe is high. It can also be shifted in one bit at a time on the falling edges of a serial clock. A marker bit starts in the top data stage and travels down the chain, so the stage knows when the word is complete. At that point it drops an active-low ready flag. When a transfer request arrives and the stack below has room, the stage hands the word on as a one-cycle push.

Several slices can sit side by side to form a wider word. For that case a master latch decides how each slice re-arms after a hand-off. A master re-arms on its own. A slave waits until its serial enable is pulled low by the slice ahead of it. Every input except the stack-room signal is asynchronous. Each of these passes through a two-flop synchronizer on the system clock, and serial clock edges are found from the synchronized samples.

Top module: `fifo_entry_stage`

## Requirements
- R1: After system reset, `in_full_n` is 1, `push_valid` is 0 and `push_word` is 0.
- R2: While the synchronized `load` is 1, the stage captures `din` and `in_full_n` goes to 0.
- R3: Each falling edge of `ser_clk` seen while `ser_en_n` and `load` are both 0 shifts in one bit. After DATA_W such edges `in_full_n` goes to 0. The first bit received lands in bit 0 of the word and the last bit in bit DATA_W-1.
- R4: Once the word is complete, further serial clock edges leave it unchanged until the stage re-arms.
- R5: Serial clock edges that arrive while `ser_en_n` is 1 shift nothing, and `in_full_n` stays 1.
- R6: A low `xfer_n` with a complete word and `stack_room` at 1 produces a one-cycle `push_valid` with the word on `push_word`. While `stack_room` is 0 there is no push, `in_full_n` stays 0 and the word is held.
- R7: One complete word gives exactly one push, however long `xfer_n` stays low. Re-arming (`in_full_n` back to 1) is held off while `load` is 1.
- R8: The master latch takes the value of "`ser_en_n` is 0" while `mreset_n` is 0. A master re-arms right after a push. A slave re-arms only once `ser_en_n` is 0.
- R9: A low `mreset_n` re-arms the stage (`in_full_n` returns to 1) and leaves `push_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| mreset_n | input | 1 | Asynchronous active-low master reset of the control state |
| load | input | 1 | Asynchronous parallel load strobe, active high |
| din | input | DATA_W | Parallel data word |
| ser_din | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial clock; a bit is taken on its falling edge |
| ser_en_n | input | 1 | Active-low serial enable; also the slave release input |
| xfer_n | input | 1 | Active-low transfer-to-stack request |
| stack_room | input | 1 | Synchronous flag: the top stack location is empty |
| in_full_n | output | 1 | Low while a complete word is held |
| push_valid | output | 1 | One-cycle push strobe toward the stack |
| push_word | output | DATA_W | Word handed to the stack, held between pushes |

## Verification
The assertions assume that each asynchronous input holds a level for at least three system clock cycles. They also assume that `ser_din` is steady across the falling edge of `ser_clk`, and that `stack_room` changes only in step with `clk`. The stimulus changes inputs only on falling system-clock edges. It holds every level, including each serial clock phase, for three or more cycles, so no edge is lost or doubled in the synchronizers. The bench sweeps all sixteen words through both the parallel path and the serial path, then covers the stack-full, slave and master-reset cases.

// File: rtl/fes_pkg.sv
// Package: shared types for the FIFO entry stage.
// Assumes: all asynchronous controls are gathered into one record before synchronization.
package fes_pkg;

    typedef struct packed {
        logic mreset_n;
        logic load;
        logic ser_clk;
        logic ser_en_n;
        logic xfer_n;
        logic ser_din;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Idle levels the synchronizer holds in reset: no load, no request, master reset released.
    localparam ctl_t CTL_IDLE = '{mreset_n: 1'b1, load: 1'b0, ser_clk: 1'b0,
                                  ser_en_n: 1'b1, xfer_n: 1'b1, ser_din: 1'b0};

endpackage

// File: rtl/fes_sync.sv
// Module: fes_sync
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is held long enough that its edges do not need to line up with other bits.
module fes_sync #(
    parameter int                 WIDTH   = 1,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;

    // Two register stages per bit; reset to the idle pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end

endmodule

// File: rtl/fes_shift_chain.sv
// Module: fes_shift_chain
// Data stages plus completion stage. A marker placed in the top data stage moves
// down one place per serial shift and sets the completion stage once the word is whole.
// Assumes: shift_en is already gated by the serial enable and the load strobe.
module fes_shift_chain #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr_n_s,
    input  logic              load_s,
    input  logic [DATA_W-1:0] din_s,
    input  logic              shift_en,
    input  logic              ser_bit,
    input  logic              reinit,
    output logic [DATA_W-1:0] word,
    output logic              full
);

    localparam logic [DATA_W-1:0] MARK = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] stage_q;
    logic              done_q;
    logic [DATA_W-1:0] shifted;

    // Next value of each stage on a shift: stage i takes stage i+1, the top stage takes the serial bit.
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_stage
            if (i == DATA_W - 1) begin : g_top
                assign shifted[i] = ser_bit;
            end else begin : g_mid
                assign shifted[i] = stage_q[i+1];
            end
        end
    endgenerate

    // Stage update in priority order: reset, master reset, parallel load, re-arm, serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= MARK;
            done_q  <= 1'b0;
        end else if (!mr_n_s) begin
            stage_q <= MARK;
            done_q  <= 1'b0;
        end else if (load_s) begin
            stage_q <= din_s;
            done_q  <= 1'b1;
        end else if (reinit) begin
            stage_q <= MARK;
            done_q  <= 1'b0;
        end else if (shift_en && !done_q) begin
            stage_q <= shifted;
            done_q  <= stage_q[0];
        end
    end

    assign word = stage_q;
    assign full = done_q;

    // R2: a sampled load always leaves the word complete.
    assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_n_s && load_s) |=> full);

    // R4: a complete word stays complete until it is re-armed or master reset.
    assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_n_s && full && !reinit) |=> full);

    // R4: further shift requests cannot alter a complete word.
    assert_word_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_n_s && full && !load_s && !reinit) |=> $stable(word));

endmodule

// File: rtl/fes_interlock.sv
// Module: fes_interlock
// Hand-off control: push decision, request-initialization flag and master latch.
// Assumes: stack_room is synchronous to clk; the other controls come from fes_sync.
module fes_interlock (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n_s,
    input  logic ser_en_n_s,
    input  logic load_s,
    input  logic xfer_n_s,
    input  logic full,
    input  logic stack_room,
    output logic push,
    output logic reinit,
    output logic is_master
);

    logic req_q;

    assign push   = mr_n_s && !xfer_n_s && full && stack_room && !req_q;
    assign reinit = mr_n_s && req_q && !load_s && (is_master || !ser_en_n_s);

    // Master latch: while master reset is held it follows "serial enable is low".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_master <= 1'b1;
        end else if (!mr_n_s) begin
            is_master <= !ser_en_n_s;
        end
    end

    // Request-initialization flag: set by a push, cleared on re-arm or master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (!mr_n_s) begin
            req_q <= 1'b0;
        end else if (push) begin
            req_q <= 1'b1;
        end else if (reinit) begin
            req_q <= 1'b0;
        end
    end

    // R7: a push is never followed directly by a second one.
    assert_one_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // R7: the pending request survives while the load strobe is high.
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && load_s && mr_n_s) |=> req_q);

    // R8: master reset with the serial enable low makes this slice a master.
    assert_master_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr_n_s && !ser_en_n_s) |=> is_master);

    // R8: a slave with its enable high does not re-arm.
    assert_slave_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && ser_en_n_s) |-> !reinit);

endmodule

// File: rtl/fifo_entry_stage.sv
// Module: fifo_entry_stage (top)
// Entry stage of a fall-through FIFO slice with serial and parallel loading,
// completion flag, hand-off to the stack and master/slave re-arm interlock.
// Assumes: asynchronous inputs hold each level for three or more clk cycles.
module fifo_entry_stage #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreset_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              ser_din,
    input  logic              ser_clk,
    input  logic              ser_en_n,
    input  logic              xfer_n,
    input  logic              stack_room,
    output logic              in_full_n,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_word
);

    import fes_pkg::*;

    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    logic [DATA_W-1:0] din_s;
    logic              sclk_prev_q;
    logic              sclk_fall;
    logic              shift_en;
    logic [DATA_W-1:0] word;
    logic              full;
    logic              push;
    logic              reinit;
    logic              is_master;

    assign ctl_raw = '{mreset_n: mreset_n, load: load, ser_clk: ser_clk,
                       ser_en_n: ser_en_n, xfer_n: xfer_n, ser_din: ser_din};

    fes_sync #(.WIDTH(CTL_W), .RST_VAL(CTL_IDLE)) u_sync_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_raw),
        .sync_out (ctl_s)
    );

    fes_sync #(.WIDTH(DATA_W), .RST_VAL('0)) u_sync_din (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (din),
        .sync_out (din_s)
    );

    // Previous synchronized serial clock, for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= ctl_s.ser_clk;
    end

    assign sclk_fall = sclk_prev_q && !ctl_s.ser_clk;
    assign shift_en  = sclk_fall && !ctl_s.ser_en_n && !ctl_s.load;

    fes_shift_chain #(.DATA_W(DATA_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .mr_n_s   (ctl_s.mreset_n),
        .load_s   (ctl_s.load),
        .din_s    (din_s),
        .shift_en (shift_en),
        .ser_bit  (ctl_s.ser_din),
        .reinit   (reinit),
        .word     (word),
        .full     (full)
    );

    fes_interlock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .mr_n_s     (ctl_s.mreset_n),
        .ser_en_n_s (ctl_s.ser_en_n),
        .load_s     (ctl_s.load),
        .xfer_n_s   (ctl_s.xfer_n),
        .full       (full),
        .stack_room (stack_room),
        .push       (push),
        .reinit     (reinit),
        .is_master  (is_master)
    );

    // Registered hand-off: one-cycle strobe, word held until the next push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_word  <= '0;
        end else begin
            push_valid <= push;
            if (push) push_word <= word;
        end
    end

    assign in_full_n = !full;

    // R6: no push strobe follows a cycle without stack room.
    assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stack_room |=> !push_valid);

    // R9: master reset never disturbs the word already handed off.
    assert_mr_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_s.mreset_n |=> $stable(push_word));

    // R7: the push strobe is one cycle wide.
    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);

endmodule

// File: tb/tb_fifo_entry_stage.sv
// Bench for fifo_entry_stage: sweeps every word through the parallel and serial
// paths, then covers stack-full, slave re-arm and master reset.
module tb_fifo_entry_stage;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mreset_n = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] din = '0;
    logic         ser_din = 1'b0;
    logic         ser_clk = 1'b0;
    logic         ser_en_n = 1'b0;
    logic         xfer_n = 1'b1;
    logic         stack_room = 1'b1;
    logic         in_full_n;
    logic         push_valid;
    logic [W-1:0] push_word;

    int           checks = 0;
    int           errors = 0;
    int           push_cnt = 0;
    logic [W-1:0] last_word = '0;

    always #4 clk = ~clk;

    fifo_entry_stage #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mreset_n(mreset_n), .load(load), .din(din),
        .ser_din(ser_din), .ser_clk(ser_clk), .ser_en_n(ser_en_n), .xfer_n(xfer_n),
        .stack_room(stack_room), .in_full_n(in_full_n), .push_valid(push_valid),
        .push_word(push_word)
    );

    // Push monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && push_valid) begin
            push_cnt++;
            last_word = push_word;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ser_edge(input logic b);
        ser_din = b;
        ser_clk = 1'b1;
        cyc(3);
        ser_clk = 1'b0;
        cyc(3);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        cyc(4);
        rst_n = 1'b1;
        cyc(4);
        // R1: reset state
        chk("R1 in_full_n", in_full_n, 1);
        chk("R1 push_valid", push_valid, 0);
        chk("R1 push_word", push_word, 0);

        // R2/R6/R7: parallel sweep over every word
        for (int v = 0; v < 16; v++) begin
            base = push_cnt;
            din = v[W-1:0];
            load = 1'b1;
            cyc(5);
            chk("R2 full after load", in_full_n, 0);
            xfer_n = 1'b0;
            cyc(6);
            chk("R6 push count", push_cnt, base + 1);
            chk("R6 pushed word", last_word, v);
            chk("R7 held while load high", in_full_n, 0);
            load = 1'b0;
            cyc(6);
            chk("R7 re-armed after load low", in_full_n, 1);
            chk("R7 single push", push_cnt, base + 1);
            xfer_n = 1'b1;
            cyc(3);
        end

        // R5: edges with serial enable high are ignored
        ser_en_n = 1'b1;
        for (int i = 0; i < 5; i++) ser_edge(1'b1);
        chk("R5 no shift when disabled", in_full_n, 1);
        ser_en_n = 1'b0;
        cyc(4);

        // R3/R4/R8: serial sweep, first bit lands in bit 0
        for (int v = 0; v < 16; v++) begin
            base = push_cnt;
            for (int i = 0; i < W; i++) begin
                if (i == W - 1) chk("R3 not full before last bit", in_full_n, 1);
                ser_edge(v[i]);
            end
            chk("R3 full after word", in_full_n, 0);
            ser_edge(~v[0]);
            ser_edge(~v[1]);
            chk("R4 still full", in_full_n, 0);
            xfer_n = 1'b0;
            cyc(6);
            chk("R3 serial push count", push_cnt, base + 1);
            chk("R4 serial word unchanged", last_word, v);
            chk("R8 master re-arms", in_full_n, 1);
            xfer_n = 1'b1;
            cyc(3);
        end

        // R6: stack full holds the word
        stack_room = 1'b0;
        base = push_cnt;
        din = 4'hA;
        load = 1'b1;
        cyc(5);
        load = 1'b0;
        xfer_n = 1'b0;
        cyc(12);
        chk("R6 no push while stack full", push_cnt, base);
        chk("R6 full held", in_full_n, 0);
        @(negedge clk) stack_room = 1'b1;
        cyc(6);
        chk("R6 push after room", push_cnt, base + 1);
        chk("R6 held word", last_word, 10);
        chk("R6 re-armed", in_full_n, 1);
        xfer_n = 1'b1;
        cyc(3);

        // R9: master reset with a complete word; becomes a slave (enable high)
        din = 4'h6;
        load = 1'b1;
        cyc(5);
        load = 1'b0;
        cyc(3);
        chk("R9 full before mreset", in_full_n, 0);
        ser_en_n = 1'b1;
        cyc(4);
        mreset_n = 1'b0;
        cyc(5);
        mreset_n = 1'b1;
        cyc(5);
        chk("R9 re-armed by mreset", in_full_n, 1);
        chk("R9 push_word kept", push_word, 10);

        // R8: slave waits for its enable
        base = push_cnt;
        din = 4'h3;
        load = 1'b1;
        cyc(5);
        xfer_n = 1'b0;
        load = 1'b0;
        cyc(8);
        chk("R8 slave pushed", push_cnt, base + 1);
        chk("R8 slave word", last_word, 3);
        chk("R8 slave waits", in_full_n, 0);
        ser_en_n = 1'b0;
        cyc(5);
        chk("R8 slave released", in_full_n, 1);
        chk("R7 slave single push", push_cnt, base + 1);
        xfer_n = 1'b1;

        // R8: back to master via mreset with enable low
        mreset_n = 1'b0;
        cyc(5);
        mreset_n = 1'b1;
        cyc(4);
        base = push_cnt;
        din = 4'hC;
        load = 1'b1;
        cyc(5);
        load = 1'b0;
        xfer_n = 1'b0;
        cyc(6);
        chk("R8 master again word", last_word, 12);
        chk("R8 master again re-arm", in_full_n, 1);
        xfer_n = 1'b1;
        cyc(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule